// File: doc/BRIEF.md
# DMA Bus Handshake Transfer Sequencer

This block governs how a single DMA channel takes and returns the system bus. When a peripheral raises its request, the sequencer asks the processor for the bus with a hold request. It waits for the hold acknowledge. It then runs one fixed three-state bus cycle for each byte. That cycle drives a pair of I/O and memory strobes that matches the transfer type, and the sequencer acknowledges the peripheral for the whole byte.

Three bus-release policies are selectable. Burst keeps the bus until the byte flagged as last. Cycle stealing hands the bus back after every byte and asks again. Transparent moves a byte only when the processor reports that it is not using the bus. The policy and the transfer type are captured when a request is accepted and hold for that whole block. Address generation, byte counting and register programming stay outside the block: the terminal-count flag comes in as an input.

Top module: `dma_bus_sequencer`

## Requirements
- R1: After reset, and until a request is seen, holdReq, addrEn, dmaAck and all four strobes are low.
- R2: A high dmaReq in the idle state raises holdReq on the next cycle. addrEn, dmaAck and the strobes stay low until holdAck has been sampled high.
- R3: Each byte takes three cycles (address, strobe, release) with dmaAck high in all three. Strobes are high only in the middle cycle.
- R4: Transfer type 2'b01 (DMA write) asserts ioRd together with memWr during the strobe cycle.
- R5: Transfer type 2'b10 (DMA read) asserts ioWr together with memRd during the strobe cycle.
- R6: Transfer type 2'b00 (verify) and 2'b11 run the full byte sequence but assert no strobe.
- R7: addrEn is high in every cycle in which the sequencer owns the bus, including gaps between bytes. It is low while idle or while waiting for holdAck.
- R8: Policy 2'b00 (burst; 2'b11 behaves the same) keeps holdReq high between bytes. It drops holdReq after the release cycle in which termCount is high.
- R9: Policy 2'b01 (cycle stealing) drops holdReq for at least one cycle after every byte. It re-requests on the following cycle if dmaReq is still high.
- R10: Policy 2'b10 (transparent) starts a byte only on the cycle after one in which cpuBusIdle was high. Otherwise it waits with the bus owned.
- R11: If holdAck falls during a byte, that byte completes. The sequencer then returns to requesting (holdReq high, addrEn low) with its policy and type kept.
- R12: Changes on xferMode and xferType after a request has been accepted have no effect until the sequencer is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| dmaReq | input | 1 | Peripheral transfer request |
| holdAck | input | 1 | Processor grants the bus |
| cpuBusIdle | input | 1 | Processor is not using the bus this cycle |
| xferMode | input | 2 | Release policy: 00 burst, 01 cycle steal, 10 transparent, 11 burst |
| xferType | input | 2 | 00 verify, 01 DMA write, 10 DMA read, 11 no strobes |
| termCount | input | 1 | Current byte is the last of the block (sampled in its release cycle) |
| holdReq | output | 1 | Bus request to the processor |
| dmaAck | output | 1 | Peripheral acknowledge for the current byte |
| ioRd | output | 1 | I/O read strobe |
| ioWr | output | 1 | I/O write strobe |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| addrEn | output | 1 | Sequencer owns the bus |

## Verification
The bench removes holdAck in the middle of a byte. A design that aborts the byte would cut dmaAck short, and one that forgets the loss would keep addrEn high. Policy and type inputs change on every cycle of a burst, so a sequencer that does not latch them would switch strobe pairs or drop the bus too early. Cycle stealing with a request that stays high checks that holdReq drops for a single cycle between bytes. Transparent runs hold cpuBusIdle low for stretches, which exposes a design that starts a byte while the processor still has the bus. Terminal count arrives on the first, a middle and the last byte of burst blocks.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    POL_BURST  = 2'b00,
    POL_STEAL  = 2'b01,
    POL_TRANSP = 2'b10,
    POL_BURSTX = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    XF_VERIFY = 2'b00,
    XF_WRITE  = 2'b01,
    XF_READ   = 2'b10,
    XF_NONE   = 2'b11
  } xfer_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ    = 3'd1,
    ST_OWN    = 3'd2,
    ST_ADDR   = 3'd3,
    ST_STROBE = 3'd4,
    ST_REL    = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic holdReq;
    logic addrEn;
    logic ack;
    logic strobeEn;
    logic capture;
  } bus_ctl_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     dmaReq,
  input  logic     holdAck,
  input  logic     cpuBusIdle,
  input  policy_e  modeIn,
  input  logic     termCount,
  output bus_ctl_t ctl
);
  seq_state_e state, stateNxt;
  policy_e    modeQ;
  logic       goByte;

  assign goByte = (modeQ == POL_TRANSP) ? cpuBusIdle : 1'b1;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (dmaReq) stateNxt = ST_REQ;
      ST_REQ:    if (holdAck) stateNxt = goByte ? ST_ADDR : ST_OWN;
      ST_OWN: begin
        if (!holdAck) stateNxt = ST_REQ;
        else if (dmaReq && goByte) stateNxt = ST_ADDR;
      end
      ST_ADDR:   stateNxt = ST_STROBE;
      ST_STROBE: stateNxt = ST_REL;
      ST_REL: begin
        if (termCount || modeQ == POL_STEAL) stateNxt = ST_IDLE;
        else if (!holdAck) stateNxt = ST_REQ;
        else if (dmaReq && goByte) stateNxt = ST_ADDR;
        else stateNxt = ST_OWN;
      end
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      modeQ <= POL_BURST;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && dmaReq) modeQ <= modeIn;
    end
  end

  always_comb begin
    ctl.holdReq  = (state != ST_IDLE);
    ctl.addrEn   = (state == ST_OWN) || (state == ST_ADDR) ||
                   (state == ST_STROBE) || (state == ST_REL);
    ctl.ack      = (state == ST_ADDR) || (state == ST_STROBE) || (state == ST_REL);
    ctl.strobeEn = (state == ST_STROBE);
    ctl.capture  = (state == ST_IDLE) && dmaReq;
  end

  // R2
  wait_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REQ && !holdAck) |=> (state == ST_REQ));

  // R8
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REL && modeQ != POL_STEAL && !termCount) |=> ctl.holdReq);

  // R9
  steal_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REL && modeQ == POL_STEAL) |=> !ctl.holdReq);

  // R10
  transp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && modeQ == POL_TRANSP) |-> $past(cpuBusIdle));

  // R11
  byte_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR) |=> (state == ST_STROBE));

  // R12
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> $stable(modeQ));
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  xfer_e    typeIn,
  input  bus_ctl_t ctl,
  output logic     holdReq,
  output logic     addrEn,
  output logic     dmaAck,
  output logic     ioRd,
  output logic     ioWr,
  output logic     memRd,
  output logic     memWr
);
  xfer_e typeQ;
  logic  isWrite, isRead;

  always_ff @(posedge clk) begin
    if (!rstN) typeQ <= XF_VERIFY;
    else if (ctl.capture) typeQ <= typeIn;
  end

  assign isWrite = (typeQ == XF_WRITE);
  assign isRead  = (typeQ == XF_READ);

  assign holdReq = ctl.holdReq;
  assign addrEn  = ctl.addrEn;
  assign dmaAck  = ctl.ack;
  assign ioRd    = ctl.strobeEn && isWrite;
  assign memWr   = ctl.strobeEn && isWrite;
  assign ioWr    = ctl.strobeEn && isRead;
  assign memRd   = ctl.strobeEn && isRead;

  // R3
  strobe_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd || ioWr || memRd || memWr) |-> (dmaAck && addrEn));

  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd || ioWr || memRd || memWr) |=> !(ioRd || ioWr || memRd || memWr));

  // R12
  type_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(typeQ));

  // R4
  pair_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((ioRd || memWr) && (ioWr || memRd)));
endmodule

// File: rtl/dma_bus_sequencer.sv
module dma_bus_sequencer
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dmaReq,
  input  logic       holdAck,
  input  logic       cpuBusIdle,
  input  logic [1:0] xferMode,
  input  logic [1:0] xferType,
  input  logic       termCount,
  output logic       holdReq,
  output logic       dmaAck,
  output logic       ioRd,
  output logic       ioWr,
  output logic       memRd,
  output logic       memWr,
  output logic       addrEn
);
  bus_ctl_t ctlBus;

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dmaReq(dmaReq), .holdAck(holdAck),
    .cpuBusIdle(cpuBusIdle), .modeIn(policy_e'(xferMode)),
    .termCount(termCount), .ctl(ctlBus)
  );

  seq_datapath u_dp (
    .clk(clk), .rstN(rstN), .typeIn(xfer_e'(xferType)), .ctl(ctlBus),
    .holdReq(holdReq), .addrEn(addrEn), .dmaAck(dmaAck),
    .ioRd(ioRd), .ioWr(ioWr), .memRd(memRd), .memWr(memWr)
  );
endmodule

// File: tb/test_dma_bus_sequencer.sv
module test_dma_bus_sequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaReq = 1'b0, holdAck = 1'b0, cpuBusIdle = 1'b0, termCount = 1'b0;
  logic [1:0] xferMode = 2'b00, xferType = 2'b00;
  logic holdReq, dmaAck, ioRd, ioWr, memRd, memWr, addrEn;

  int checks = 0;
  int errors = 0;
  // reference state: 0 idle, 1 req, 2 own, 3 addr, 4 strobe, 5 release
  int mState = 0;
  logic [1:0] mMode = 0, mType = 0;

  always #2 clk = ~clk;

  dma_bus_sequencer i_dma_bus_sequencer (
    .clk(clk), .rstN(rstN), .dmaReq(dmaReq), .holdAck(holdAck),
    .cpuBusIdle(cpuBusIdle), .xferMode(xferMode), .xferType(xferType),
    .termCount(termCount), .holdReq(holdReq), .dmaAck(dmaAck),
    .ioRd(ioRd), .ioWr(ioWr), .memRd(memRd), .memWr(memWr), .addrEn(addrEn)
  );

  function automatic logic [6:0] expOut(int st, logic [1:0] ty);
    logic s;
    s = (st == 4);
    // {holdReq, addrEn, dmaAck, ioRd, memWr, ioWr, memRd}
    return {st != 0, st >= 2, st >= 3, s && ty == 2'b01, s && ty == 2'b01,
            s && ty == 2'b10, s && ty == 2'b10};
  endfunction

  function automatic int nextState(int st, logic rq, logic ha, logic idl,
                                   logic [1:0] md, logic tc);
    logic go;
    go = (md == 2'b10) ? idl : 1'b1;
    case (st)
      0: return rq ? 1 : 0;
      1: return ha ? (go ? 3 : 2) : 1;
      2: return !ha ? 1 : ((rq && go) ? 3 : 2);
      3: return 4;
      4: return 5;
      default: begin
        if (tc || md == 2'b01) return 0;
        if (!ha) return 1;
        return (rq && go) ? 3 : 2;
      end
    endcase
  endfunction

  task automatic compare(string tag);
    logic [6:0] e, a;
    e = expOut(mState, mType);
    a = {holdReq, addrEn, dmaAck, ioRd, memWr, ioWr, memRd};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: outputs {hold,aen,ack,ioRd,memWr,ioWr,memRd} actual %b expected %b (ref state %0d)",
               tag, a, e, mState);
    end
  endtask

  task automatic step(logic rq, logic ha, logic idl, logic [1:0] md,
                      logic [1:0] ty, logic tc, string tag);
    int nx;
    compare(tag);
    nx = nextState(mState, rq, ha, idl, mMode, tc);
    if (mState == 0 && rq) begin
      mMode = md;
      mType = ty;
    end
    dmaReq = rq; holdAck = ha; cpuBusIdle = idl;
    xferMode = md; xferType = ty; termCount = tc;
    @(posedge clk);
    mState = nx;
    @(negedge clk);
  endtask

  task automatic drain(string tag);
    for (int k = 0; k < 12 && mState != 0; k++) step(1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 1'b1, tag);
    step(1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bytes;
    void'($urandom(32'd5417));
    // R1: reset state
    repeat (3) @(negedge clk);
    compare("R1");
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b0, 2'b00, 2'b01, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b1, 2'b00, 2'b01, 1'b0, "R1");

    // R2: request without grant, then grant; R4 write burst, R8 end on tc
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b1, 2'b00, 2'b01, 1'b0, "R2");
    bytes = 0;
    for (int k = 0; k < 20 && !(bytes == 3 && mState == 0); k++) begin
      if (mState == 5) bytes++;
      step(1'b1, 1'b1, 1'b0, 2'b00, 2'b01, (mState == 5 && bytes == 3), "R4 R8");
    end
    drain("R8");

    // R5 read type under cycle stealing, R9
    for (int k = 0; k < 24; k++) step(1'b1, 1'b1, 1'b0, 2'b01, 2'b10, 1'b0, "R5 R9");
    drain("R9");

    // R6 verify under transparent, R10 with idle windows
    for (int k = 0; k < 40; k++)
      step(1'b1, 1'b1, (k % 7) >= 4, 2'b10, 2'b00, 1'b0, "R6 R10");
    drain("R10");
    for (int k = 0; k < 12; k++) step(1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 1'b0, "R6");
    drain("R6");

    // R11: grant removed in the middle of a byte
    for (int k = 0; k < 30; k++)
      step(1'b1, !(mState == 4 || (k > 8 && k < 13)), 1'b0, 2'b00, 2'b01, 1'b0, "R11");
    drain("R11");

    // R12: mode and type flip every cycle once a read burst is accepted
    step(1'b1, 1'b1, 1'b0, 2'b00, 2'b10, 1'b0, "R12");
    for (int k = 0; k < 20; k++)
      step(1'b1, 1'b1, 1'b0, 2'(k % 4), 2'((k + 1) % 4), 1'b0, "R12");
    drain("R12");

    // random mix, R3 R7 byte sequence and bus ownership
    for (int k = 0; k < 4000; k++) begin
      logic rq, ha, idl, tc;
      logic [1:0] md, ty;
      rq = ($urandom % 4) != 0;
      ha = ($urandom % 8) != 0;
      idl = ($urandom % 2) != 0;
      tc = ($urandom % 6) == 0;
      md = 2'($urandom % 4);
      ty = 2'($urandom % 4);
      step(rq, ha, idl, md, ty, tc, "R3 R7");
    end
    drain("R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule